// File: doc/BRIEF.md
# Shared-Pin Bus Phase Sequencer

This block lets one group of FPGA pins carry the address, the control/status lines and the data of a processor bus cycle in turn. Two sets of external buffers sit in front of the pins. One carries the address/data lines and the other carries the control/status lines. The sequencer runs on a 100 MHz clock, so one clock step is 10 ns. It watches the processor's address latch strobe and captures the address from the pins. It then swaps the buffers so that the status lines can be read, and then gives the pins back to the address/data buffers for the data part of the cycle.

The three step lengths are parameters given in clock counts:

- `ADDR_TO_CTRL` sets the delay from the address capture to the buffer swap.
- `CTRL_SAMPLE` sets how long the control buffer is open before its lines are latched.
- `CTRL_HOLD` sets how long the control buffer stays open after the latch.

`CTRL_SAMPLE` can be raised for processors that are slow to drive their status lines. `GUARD_IDLE` adds one clock at each buffer swap in which neither buffer is enabled. The block captures exactly once per strobe assertion. It only re-arms after the strobe has been seen low.

Top module: `bus_phase_seq`

## Requirements
- R1: While reset is held and right after it, `ad_en_o` is 1, `ctrl_en_o` is 0, both valid strobes are 0, and `addr_o` and `ctrl_o` are 0.
- R2: The address is taken from `pins_i` at the first rising edge where `strobe_i` is sampled high and was also sampled high at the edge before. `addr_o` shows it, and `addr_vld_o` is high for exactly one cycle, from that edge on.
- R3: A strobe that is high at only one sampling edge captures nothing: no `addr_vld_o` occurs and `ctrl_en_o` stays 0.
- R4: `ctrl_en_o` and `ad_en_o` are never both 1.
- R5: `ADDR_TO_CTRL` edges after the address capture edge (default 1, which is 10 ns), `ad_en_o` goes to 0 and `ctrl_en_o` goes to 1 at the same edge when `GUARD_IDLE` is 0.
- R6: `pins_i[CTRL_W-1:0]` is latched into `ctrl_o` `CTRL_SAMPLE` edges after `ctrl_en_o` rises (default 2, which is 20 ns). `ctrl_vld_o` is high for one cycle from that edge.
- R7: `ctrl_en_o` stays high for `CTRL_SAMPLE + CTRL_HOLD` cycles (default 4, which is 40 ns). When it falls, `ad_en_o` returns to 1 for the data phase.
- R8: A strobe held high for many cycles yields one capture only. A new capture needs the strobe to have been sampled low at least once.
- R9: With `GUARD_IDLE` = 1, exactly one cycle with both enables at 0 is inserted before `ctrl_en_o` rises and another one after it falls. The control window length stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Address latch strobe from the processor |
| pins_i | input | PIN_W | Shared pin group, as seen through whichever buffer is enabled |
| addr_o | output | PIN_W | Captured address |
| ctrl_o | output | CTRL_W | Captured control/status word |
| addr_vld_o | output | 1 | One-cycle pulse when a new address is present |
| ctrl_vld_o | output | 1 | One-cycle pulse when a new control word is present |
| ad_en_o | output | 1 | Enable for the address/data buffers |
| ctrl_en_o | output | 1 | Enable for the control/status buffer |

## Verification
The hardest situations to reach from the ports are those where the strobe does not behave like one clean pulse per cycle. One case is a strobe held high through the whole control window and beyond it. The other is a strobe that is high at only a single sampling edge. The stimulus drives both of these cases and then runs further normal bus cycles. A scoreboard would flag any extra capture as a valid pulse that matches no queued expectation.

The shared pins change their value between the address step and the control step, and once more after the control sample. A capture taken one edge early or one edge late therefore returns the wrong word. A second instance built with the guard option sees the same stimulus, so the timing of its idle cycles is checked against the same bus cycles.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_GAP_A,
    PH_CTRL_SU,
    PH_CTRL_HOLD,
    PH_GAP_B
  } phase_e;
endpackage

// File: rtl/bus_seq_strobe_det.sv
module bus_seq_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic accept_i,
  output logic cap_o
);
  logic hist_q;
  logic armed_q;

  assign cap_o = accept_i && armed_q && hist_q && strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      hist_q <= strobe_i;
      if (!strobe_i)  armed_q <= 1'b1;
      else if (cap_o) armed_q <= 1'b0;
    end
  end

  // after a capture no second one may happen before the strobe drops
  AST_NO_REARM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o ##1 strobe_i) |-> !cap_o); // R8
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int  ADDR_TO_CTRL = 1,
  parameter int  CTRL_SAMPLE  = 2,
  parameter int  CTRL_HOLD    = 2,
  parameter bit  GUARD_IDLE   = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cap_i,
  output logic   accept_o,
  output logic   ctrl_cap_o,
  output logic   ad_en_o,
  output logic   ctrl_en_o
);
  localparam int MAXD_A = (ADDR_TO_CTRL > CTRL_SAMPLE) ? ADDR_TO_CTRL : CTRL_SAMPLE;
  localparam int MAXD   = (MAXD_A > CTRL_HOLD) ? MAXD_A : CTRL_HOLD;
  localparam int CNT_W  = (MAXD < 2) ? 1 : $clog2(MAXD);

  localparam logic [CNT_W-1:0] LD_PRE  = CNT_W'(ADDR_TO_CTRL - 1);
  localparam logic [CNT_W-1:0] LD_SU   = CNT_W'(CTRL_SAMPLE - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(CTRL_HOLD - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           after_pre, after_hold;

  generate
    if (GUARD_IDLE) begin : g_guard
      assign after_pre  = PH_GAP_A;
      assign after_hold = PH_GAP_B;
    end else begin : g_direct
      assign after_pre  = PH_CTRL_SU;
      assign after_hold = PH_IDLE;
    end
  endgenerate

  wire cnt_done = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (cap_i) begin
        ph_d  = PH_PRE;
        cnt_d = LD_PRE;
      end
      PH_PRE: begin
        if (cnt_done) begin
          ph_d  = after_pre;
          cnt_d = LD_SU;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_GAP_A: begin
        ph_d  = PH_CTRL_SU;
        cnt_d = LD_SU;
      end
      PH_CTRL_SU: begin
        if (cnt_done) begin
          ph_d  = PH_CTRL_HOLD;
          cnt_d = LD_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_CTRL_HOLD: begin
        if (cnt_done) ph_d = after_hold;
        else          cnt_d = cnt_q - 1'b1;
      end
      PH_GAP_B: ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign accept_o   = (ph_q == PH_IDLE);
  assign ctrl_cap_o = (ph_q == PH_CTRL_SU) && cnt_done;
  assign ad_en_o    = (ph_q == PH_IDLE) || (ph_q == PH_PRE);
  assign ctrl_en_o  = (ph_q == PH_CTRL_SU) || (ph_q == PH_CTRL_HOLD);

  AST_GUARD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GUARD_IDLE && $rose(ctrl_en_o)) |-> $past(!ad_en_o)); // R9
endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture #(
  parameter int PIN_W  = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic              addr_cap_i,
  input  logic              ctrl_cap_i,
  output logic [PIN_W-1:0]  addr_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              addr_vld_o,
  output logic              ctrl_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      ctrl_o     <= '0;
      addr_vld_o <= 1'b0;
      ctrl_vld_o <= 1'b0;
    end else begin
      addr_vld_o <= addr_cap_i;
      ctrl_vld_o <= ctrl_cap_i;
      if (addr_cap_i) addr_o <= pins_i;
      if (ctrl_cap_i) ctrl_o <= pins_i[CTRL_W-1:0];
    end
  end

  AST_ADDR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |=> !addr_vld_o); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_o |-> $stable(addr_o)); // R2
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq #(
  parameter int PIN_W        = 16,
  parameter int CTRL_W       = 8,
  parameter int ADDR_TO_CTRL = 1,
  parameter int CTRL_SAMPLE  = 2,
  parameter int CTRL_HOLD    = 2,
  parameter bit GUARD_IDLE   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [PIN_W-1:0]  pins_i,
  output logic [PIN_W-1:0]  addr_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              addr_vld_o,
  output logic              ctrl_vld_o,
  output logic              ad_en_o,
  output logic              ctrl_en_o
);
  localparam int WIN   = CTRL_SAMPLE + CTRL_HOLD;
  localparam int WIN_W = $clog2(WIN + 2);

  logic addr_cap, ctrl_cap, accept;

  bus_seq_strobe_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .accept_i (accept),
    .cap_o    (addr_cap)
  );

  bus_seq_fsm #(
    .ADDR_TO_CTRL (ADDR_TO_CTRL),
    .CTRL_SAMPLE  (CTRL_SAMPLE),
    .CTRL_HOLD    (CTRL_HOLD),
    .GUARD_IDLE   (GUARD_IDLE)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (addr_cap),
    .accept_o   (accept),
    .ctrl_cap_o (ctrl_cap),
    .ad_en_o    (ad_en_o),
    .ctrl_en_o  (ctrl_en_o)
  );

  bus_seq_capture #(
    .PIN_W  (PIN_W),
    .CTRL_W (CTRL_W)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pins_i     (pins_i),
    .addr_cap_i (addr_cap),
    .ctrl_cap_i (ctrl_cap),
    .addr_o     (addr_o),
    .ctrl_o     (ctrl_o),
    .addr_vld_o (addr_vld_o),
    .ctrl_vld_o (ctrl_vld_o)
  );

  // window length watcher for the control buffer
  logic [WIN_W-1:0] win_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= '0;
    else if (ctrl_en_o) win_q <= win_q + 1'b1;
    else                win_q <= '0;
  end

  AST_EN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_en_o && ad_en_o)); // R4
  AST_CTRL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_en_o) |-> (win_q == WIN_W'(WIN))); // R7
  AST_SAMPLE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_vld_o |-> $past(ctrl_en_o)); // R6
  AST_ADDR_AFTER_TWO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> ($past(strobe_i, 1) && $past(strobe_i, 2))); // R2
endmodule

// File: tb/sim_bus_phase_seq.sv
module sim_bus_phase_seq;
  localparam int PIN_W  = 16;
  localparam int CTRL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [PIN_W-1:0] pins = '0;

  logic [PIN_W-1:0]  addr0, addr1;
  logic [CTRL_W-1:0] ctrl0, ctrl1;
  logic av0, cv0, ad0, ce0, av1, cv1, ad1, ce1;

  always #5 clk = ~clk;

  bus_phase_seq #(.PIN_W(PIN_W), .CTRL_W(CTRL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .pins_i(pins),
    .addr_o(addr0), .ctrl_o(ctrl0), .addr_vld_o(av0), .ctrl_vld_o(cv0),
    .ad_en_o(ad0), .ctrl_en_o(ce0));

  bus_phase_seq #(.PIN_W(PIN_W), .CTRL_W(CTRL_W), .GUARD_IDLE(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .pins_i(pins),
    .addr_o(addr1), .ctrl_o(ctrl1), .addr_vld_o(av1), .ctrl_vld_o(cv1),
    .ad_en_o(ad1), .ctrl_en_o(ce1));

  int checks = 0;
  int failures = 0;
  int addr_seen = 0;
  int issued = 0;
  bit finished = 1'b0;

  logic [PIN_W-1:0]  exp_addr_q[$];
  logic [CTRL_W-1:0] exp_ctrl_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(ad0 && ce0) && !(ad1 && ce1), "R4", {ad0, ce0, ad1, ce1}, 0);
      if (av0) begin
        addr_seen++;
        if (exp_addr_q.size() == 0) chk(1'b0, "R8 unexpected address", 32'(addr0), 0);
        else begin
          automatic logic [PIN_W-1:0] e = exp_addr_q.pop_front();
          chk(addr0 == e, "R2 address", 32'(addr0), 32'(e));
        end
      end
      if (cv0) begin
        if (exp_ctrl_q.size() == 0) chk(1'b0, "R6 unexpected control", 32'(ctrl0), 0);
        else begin
          automatic logic [CTRL_W-1:0] e = exp_ctrl_q.pop_front();
          chk(ctrl0 == e, "R6 control", 32'(ctrl0), 32'(e));
        end
      end
    end
  end

  // driver: one bus cycle; n<k> is the negedge after the k-th posedge
  task automatic bus_cycle(input logic [PIN_W-1:0] a, input logic [CTRL_W-1:0] c, input bit long_hi);
    @(negedge clk);
    strobe = 1'b1;
    pins = a;
    exp_addr_q.push_back(a);
    exp_ctrl_q.push_back(c);
    issued++;
    @(negedge clk);                                   // n1
    chk(!av0, "R2 no capture after one high", av0, 0);
    @(negedge clk);                                   // n2
    chk(av0 && ad0 && !ce0, "R5 still address phase", {av0, ad0, ce0}, 3'b110);
    pins = ~a;
    @(negedge clk);                                   // n3
    chk(ce0 && !ad0, "R5 swap after one clock", {ce0, ad0}, 2'b10);
    chk(!ce1 && !ad1, "R9 guard gap before control", {ce1, ad1}, 2'b00);
    pins = {{(PIN_W-CTRL_W){1'b1}}, c};
    if (!long_hi) strobe = 1'b0;
    @(negedge clk);                                   // n4
    chk(!cv0, "R6 not sampled early", cv0, 0);
    chk(ce1 && !ad1, "R9 guarded control on", {ce1, ad1}, 2'b10);
    @(negedge clk);                                   // n5
    chk(cv0 && ctrl0 == c && ce0, "R6 sampled at second clock", {cv0, ce0, ctrl0}, {2'b11, c});
    pins = ~pins;
    @(negedge clk);                                   // n6
    chk(ce0, "R7 window open", ce0, 1);
    @(negedge clk);                                   // n7
    chk(!ce0 && ad0, "R7 data phase after 40 ns", {ce0, ad0}, 2'b01);
    chk(ce1, "R9 guarded window open", ce1, 1);
    @(negedge clk);                                   // n8
    chk(!ce1 && !ad1, "R9 guard gap after control", {ce1, ad1}, 2'b00);
    @(negedge clk);                                   // n9
    chk(ad1 && !ce1, "R9 data phase restored", {ad1, ce1}, 2'b10);
    if (long_hi) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!ce0 && ad0, "R8 held strobe idle", {ce0, ad0}, 2'b01);
      end
      strobe = 1'b0;
      @(negedge clk);
      chk(addr_seen == issued, "R8 one capture per strobe", addr_seen, issued);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ad0 && !ce0 && !av0 && !cv0 && addr0 == 0 && ctrl0 == 0, "R1 in reset",
        {ad0, ce0, av0, cv0}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ad0 && !ce0 && !av0 && !cv0 && addr0 == 0 && ctrl0 == 0, "R1 after reset",
        {ad0, ce0, av0, cv0}, 4'b1000);

    bus_cycle(16'h1234, 8'hA5, 1'b0);
    bus_cycle(16'hFFFF, 8'h00, 1'b0);
    bus_cycle(16'h0001, 8'hFF, 1'b1);
    bus_cycle(16'h8000, 8'h3C, 1'b0);

    // R3: strobe high at a single edge only
    @(negedge clk);
    strobe = 1'b1;
    pins = 16'hBEEF;
    @(negedge clk);
    strobe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!ce0 && ad0 && !av0, "R3 short strobe ignored", {ce0, ad0, av0}, 3'b010);
    end
    chk(addr_seen == issued, "R3 no extra capture", addr_seen, issued);

    bus_cycle(16'h5A5A, 8'h81, 1'b0);
    bus_cycle(16'hC3C3, 8'h7E, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_addr_q.size() == 0 && exp_ctrl_q.size() == 0, "R2 all results seen",
        exp_addr_q.size() + exp_ctrl_q.size(), 0);
    chk(addr_seen == issued, "R8 total captures", addr_seen, issued);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule